// File: doc/BRIEF.md
# Morse symbol accumulator and decoder

This block gathers a running sequence of Morse symbols and turns it, at every step, into a 6-bit character code. Each accepted symbol is packed as a 2-bit code into a 10-bit shift register that holds at most five symbols. The newest symbol always sits in the lowest pair. A separate 3-bit count records how many pairs are in use, because the dot code is the same as an empty slot. The character code comes from combinational logic on the register and the count, so it follows every new symbol at once.

Symbols arrive as a one-cycle strobe together with a dash flag; the press timing that produces them lies outside the block. A clear button empties the register and the count. The clear only takes effect after the button has been held without a break for `HOLD_TICKS` periods of a slow tick, so a brief tap leaves the stored sequence alone.

Top module: `morse_accum`

## Requirements
- R1: A synchronous active-high `rst` sets `seq_bits` to 0 and `sym_count` to 0, which makes `char_code` 62.
- R2: A `sym_valid` strobe with fewer than five symbols stored shifts `seq_bits` left by two bits. The new symbol enters bits [1:0] as 2'b00 for a dot (`sym_dash`=0) or 2'b01 for a dash. `sym_count` rises by one on the next clock.
- R3: `sym_count` never exceeds 5. In every pair, the upper bit and all pairs at or above index `sym_count` stay 0.
- R4: While five symbols are stored, a `sym_valid` strobe changes neither `seq_bits` nor `sym_count`.
- R5: Holding `clr_btn` for fewer than `HOLD_TICKS` `tick` pulses leaves the contents unchanged. Releasing the button restarts the hold measurement from zero.
- R6: On the clock edge that carries the `HOLD_TICKS`-th `tick` of an unbroken hold, `seq_bits` and `sym_count` both become 0. This clear wins over a `sym_valid` strobe in the same cycle. Staying held afterwards causes no further clear until the button is released.
- R7: `char_code` follows Morse code: digits 0–9 give codes 0–9, letters A–Z give codes 10–35, and a count of 0 gives 62. Any stored sequence that is not a letter or digit gives 63. The first symbol sent is the most significant of the used pairs.
- R8: `char_code` shows the decode of the new contents in the same cycle that `seq_bits` and `sym_count` show them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Slow time-base pulse, one cycle wide, used for the clear hold |
| sym_valid | input | 1 | One-cycle strobe: a symbol is present |
| sym_dash | input | 1 | Symbol kind with the strobe: 1 dash, 0 dot |
| clr_btn | input | 1 | Clear button level, active high |
| seq_bits | output | 10 | Stored symbol pairs, newest in bits [1:0] |
| sym_count | output | 3 | Number of stored symbols, 0 to 5 |
| char_code | output | 6 | Decoded character code |

## Verification
The hardest case to reach is a hold that ends exactly on the qualifying tick while a symbol strobe arrives in the same cycle. The clear must win there, and it must not fire again while the button stays down. The bench gets there by counting tick pulses one at a time under a held button, and it uses a small `HOLD_TICKS`. It releases and re-presses the button one tick short of the limit to show the restart. On the final tick it raises `sym_valid` together with the tick.

// File: rtl/morse_pkg.sv
package morse_pkg;

    localparam int unsigned SYM_W   = 2;
    localparam int unsigned MAX_SYM = 5;
    localparam int unsigned SEQ_W   = SYM_W * MAX_SYM;
    localparam int unsigned CNT_W   = $clog2(MAX_SYM + 1);
    localparam int unsigned CODE_W  = 6;

    localparam logic [CODE_W-1:0] CODE_EMPTY = 6'd62;
    localparam logic [CODE_W-1:0] CODE_BAD   = 6'd63;
    localparam logic [CNT_W-1:0]  CNT_FULL   = CNT_W'(MAX_SYM);

    typedef enum logic [SYM_W-1:0] {
        SYM_DOT  = 2'b00,
        SYM_DASH = 2'b01
    } sym_code_e;

    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic [SEQ_W-1:0] bits;
    } seq_state_t;

    // One bit per stored pair, 1 = dash; pair 0 (newest) lands in bit 0.
    function automatic logic [MAX_SYM-1:0] dash_pattern(input logic [SEQ_W-1:0] bits);
        logic [MAX_SYM-1:0] p;
        for (int i = 0; i < int'(MAX_SYM); i++) begin
            p[i] = bits[i*SYM_W];
        end
        return p;
    endfunction

    function automatic logic [CODE_W-1:0] decode(input logic [CNT_W-1:0] n,
                                                 input logic [MAX_SYM-1:0] p);
        logic [CODE_W-1:0] c;
        if (n == '0) return CODE_EMPTY;
        case ({n, p})
            {3'd1, 5'b00000}: c = 6'd14;  // E
            {3'd1, 5'b00001}: c = 6'd29;  // T
            {3'd2, 5'b00000}: c = 6'd18;  // I
            {3'd2, 5'b00001}: c = 6'd10;  // A
            {3'd2, 5'b00010}: c = 6'd23;  // N
            {3'd2, 5'b00011}: c = 6'd22;  // M
            {3'd3, 5'b00000}: c = 6'd28;  // S
            {3'd3, 5'b00001}: c = 6'd30;  // U
            {3'd3, 5'b00010}: c = 6'd27;  // R
            {3'd3, 5'b00011}: c = 6'd32;  // W
            {3'd3, 5'b00100}: c = 6'd13;  // D
            {3'd3, 5'b00101}: c = 6'd20;  // K
            {3'd3, 5'b00110}: c = 6'd16;  // G
            {3'd3, 5'b00111}: c = 6'd24;  // O
            {3'd4, 5'b00000}: c = 6'd17;  // H
            {3'd4, 5'b00001}: c = 6'd31;  // V
            {3'd4, 5'b00010}: c = 6'd15;  // F
            {3'd4, 5'b00100}: c = 6'd21;  // L
            {3'd4, 5'b00110}: c = 6'd25;  // P
            {3'd4, 5'b00111}: c = 6'd19;  // J
            {3'd4, 5'b01000}: c = 6'd11;  // B
            {3'd4, 5'b01001}: c = 6'd33;  // X
            {3'd4, 5'b01010}: c = 6'd12;  // C
            {3'd4, 5'b01011}: c = 6'd34;  // Y
            {3'd4, 5'b01100}: c = 6'd35;  // Z
            {3'd4, 5'b01101}: c = 6'd26;  // Q
            {3'd5, 5'b11111}: c = 6'd0;
            {3'd5, 5'b01111}: c = 6'd1;
            {3'd5, 5'b00111}: c = 6'd2;
            {3'd5, 5'b00011}: c = 6'd3;
            {3'd5, 5'b00001}: c = 6'd4;
            {3'd5, 5'b00000}: c = 6'd5;
            {3'd5, 5'b10000}: c = 6'd6;
            {3'd5, 5'b11000}: c = 6'd7;
            {3'd5, 5'b11100}: c = 6'd8;
            {3'd5, 5'b11110}: c = 6'd9;
            default:          c = CODE_BAD;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/morse_clr_hold.sv
module morse_clr_hold #(
    parameter int unsigned HOLD_TICKS = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic btn,
    output logic clr_go
);
    localparam int unsigned HC_W = $clog2(HOLD_TICKS + 1);
    localparam logic [HC_W-1:0] HC_LAST = HC_W'(HOLD_TICKS - 1);
    localparam logic [HC_W-1:0] HC_DONE = HC_W'(HOLD_TICKS);

    logic [HC_W-1:0] held_ticks;

    always_ff @(posedge clk) begin
        if (rst || !btn) begin
            held_ticks <= '0;
        end else if (tick && held_ticks != HC_DONE) begin
            held_ticks <= held_ticks + HC_W'(1);
        end
    end

    assign clr_go = btn && tick && (held_ticks == HC_LAST);

    generate
        if (HOLD_TICKS > 1) begin : g_tap_chk
            AST_TAP_NO_CLEAR: assert property (@(posedge clk) disable iff (rst)
                $rose(btn) |-> !clr_go);  // R5
        end
    endgenerate

    AST_ONE_CLEAR_PER_HOLD: assert property (@(posedge clk) disable iff (rst)
        (clr_go && btn) |=> (btn -> !clr_go));  // R6

endmodule

// File: rtl/morse_seq_reg.sv
module morse_seq_reg
    import morse_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       clr,
    input  logic       push,
    input  logic       dash,
    output seq_state_t state
);
    sym_code_e  new_sym;
    seq_state_t nxt;
    logic       full;

    assign full    = (state.count == CNT_FULL);
    assign new_sym = dash ? SYM_DASH : SYM_DOT;

    always_comb begin
        nxt = state;
        if (clr) begin
            nxt = '0;
        end else if (push && !full) begin
            nxt.bits  = {state.bits[SEQ_W-SYM_W-1:0], new_sym};
            nxt.count = state.count + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state <= '0;
        else     state <= nxt;
    end

    AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (rst)
        state.count <= CNT_FULL);  // R3

    AST_SHIFT_IN: assert property (@(posedge clk) disable iff (rst)
        (push && !clr && state.count < CNT_FULL) |=>
        (state.count == $past(state.count) + CNT_W'(1)) &&
        (state.bits[SYM_W-1:0] == {1'b0, $past(dash)}) &&
        (state.bits[SEQ_W-1:SYM_W] == $past(state.bits[SEQ_W-SYM_W-1:0])));  // R2

    AST_FULL_IGNORE: assert property (@(posedge clk) disable iff (rst)
        (push && !clr && state.count == CNT_FULL) |=>
        $stable(state.bits) && state.count == CNT_FULL);  // R4

    genvar g;
    generate
        for (g = 0; g < int'(MAX_SYM); g++) begin : g_pair_chk
            AST_PAIR_CLEAN: assert property (@(posedge clk) disable iff (rst)
                !state.bits[g*SYM_W+1] &&
                ((state.count <= CNT_W'(g)) -> (state.bits[g*SYM_W] == 1'b0)));  // R3
        end
    endgenerate

endmodule

// File: rtl/morse_xlate.sv
module morse_xlate
    import morse_pkg::*;
(
    input  seq_state_t        state,
    output logic [CODE_W-1:0] code
);
    logic [MAX_SYM-1:0] pat;

    always_comb begin
        pat  = dash_pattern(state.bits);
        code = decode(state.count, pat);
    end
endmodule

// File: rtl/morse_accum.sv
module morse_accum
    import morse_pkg::*;
#(
    parameter int unsigned HOLD_TICKS = 1000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              sym_valid,
    input  logic              sym_dash,
    input  logic              clr_btn,
    output logic [SEQ_W-1:0]  seq_bits,
    output logic [CNT_W-1:0]  sym_count,
    output logic [CODE_W-1:0] char_code
);
    logic       clr_go;
    seq_state_t st;

    morse_clr_hold #(.HOLD_TICKS(HOLD_TICKS)) u_hold (
        .clk    (clk),
        .rst    (rst),
        .tick   (tick),
        .btn    (clr_btn),
        .clr_go (clr_go)
    );

    morse_seq_reg u_seq (
        .clk   (clk),
        .rst   (rst),
        .clr   (clr_go),
        .push  (sym_valid),
        .dash  (sym_dash),
        .state (st)
    );

    morse_xlate u_xlate (
        .state (st),
        .code  (char_code)
    );

    assign seq_bits  = st.bits;
    assign sym_count = st.count;

    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        clr_go |=> (sym_count == '0 && seq_bits == '0));  // R6

    AST_EMPTY_CODE: assert property (@(posedge clk) disable iff (rst)
        (sym_count == '0) |-> (char_code == CODE_EMPTY));  // R7

    AST_CODE_RANGE: assert property (@(posedge clk) disable iff (rst)
        (char_code <= 6'd35) || (char_code == CODE_BAD) ||
        (char_code == CODE_EMPTY && sym_count == '0));  // R7

    AST_RESET_STATE: assert property (@(posedge clk)
        rst |=> (sym_count == '0 && seq_bits == '0));  // R1

endmodule

// File: tb/morse_accum_test.sv
module morse_accum_test;
    localparam int HOLD = 4;

    logic       clk = 1'b0;
    logic       rst, tick, sym_valid, sym_dash, clr_btn;
    logic [9:0] seq_bits;
    logic [2:0] sym_count;
    logic [5:0] char_code;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    morse_accum #(.HOLD_TICKS(HOLD)) uut (
        .clk(clk), .rst(rst), .tick(tick), .sym_valid(sym_valid),
        .sym_dash(sym_dash), .clr_btn(clr_btn), .seq_bits(seq_bits),
        .sym_count(sym_count), .char_code(char_code)
    );

    // {count[2:0], pattern[4:0] first symbol highest, expected code[5:0]}
    localparam int NV = 18;
    localparam logic [13:0] VEC [NV] = '{
        {3'd1, 5'b00000, 6'd14}, {3'd1, 5'b00001, 6'd29},
        {3'd2, 5'b00001, 6'd10}, {3'd2, 5'b00010, 6'd23},
        {3'd2, 5'b00011, 6'd22}, {3'd3, 5'b00000, 6'd28},
        {3'd3, 5'b00111, 6'd24}, {3'd3, 5'b00101, 6'd20},
        {3'd4, 5'b00000, 6'd17}, {3'd4, 5'b01000, 6'd11},
        {3'd4, 5'b01101, 6'd26}, {3'd4, 5'b01100, 6'd35},
        {3'd4, 5'b00011, 6'd63}, {3'd5, 5'b11111, 6'd0},
        {3'd5, 5'b00000, 6'd5},  {3'd5, 5'b11110, 6'd9},
        {3'd5, 5'b00011, 6'd3},  {3'd5, 5'b01010, 6'd63}
    };

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic send(input logic d);
        sym_valid = 1'b1;
        sym_dash  = d;
        @(negedge clk);
        sym_valid = 1'b0;
        sym_dash  = 1'b0;
    endtask

    task automatic pulse_tick();
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
    endtask

    function automatic logic [9:0] pack_bits(input int n, input logic [4:0] p);
        logic [9:0] b = '0;
        for (int j = 0; j < n; j++) b[2*j] = p[j];
        return b;
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; tick = 1'b0; sym_valid = 1'b0; sym_dash = 1'b0; clr_btn = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        check("R1 reset count", int'(sym_count), 0);
        check("R1 reset bits", int'(seq_bits), 0);
        check("R1 R7 reset code", int'(char_code), 62);

        // Table walk: each entry from an empty register
        for (int v = 0; v < NV; v++) begin
            automatic int         n  = int'(VEC[v][13:11]);
            automatic logic [4:0] p  = VEC[v][10:6];
            automatic int         ex = int'(VEC[v][5:0]);
            do_reset();
            for (int k = n - 1; k >= 0; k--) send(p[k]);
            check("R2 count", int'(sym_count), n);
            check("R2 R3 bits", int'(seq_bits), int'(pack_bits(n, p)));
            check("R7 R8 code", int'(char_code), ex);
        end

        // R8: code after first symbol already valid
        do_reset();
        send(1'b1);
        check("R8 code after one dash", int'(char_code), 29);
        send(1'b0);
        check("R8 code after dash dot", int'(char_code), 23);

        // R4: sixth symbol ignored
        do_reset();
        for (int k = 0; k < 5; k++) send(1'b0);
        send(1'b1);
        check("R4 full count", int'(sym_count), 5);
        check("R4 full bits", int'(seq_bits), 0);
        check("R4 full code", int'(char_code), 5);

        // R1: reset mid-sequence
        send(1'b1);
        do_reset();
        check("R1 mid reset count", int'(sym_count), 0);
        check("R1 mid reset code", int'(char_code), 62);

        // R5: short hold and restart
        send(1'b1);
        send(1'b0);
        clr_btn = 1'b1;
        for (int k = 0; k < HOLD - 1; k++) pulse_tick();
        check("R5 short hold count", int'(sym_count), 2);
        clr_btn = 1'b0;
        @(negedge clk);
        clr_btn = 1'b1;
        for (int k = 0; k < HOLD - 1; k++) pulse_tick();
        check("R5 restart count", int'(sym_count), 2);
        check("R5 restart bits", int'(seq_bits), 4);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        check("R6 clear count", int'(sym_count), 0);
        check("R6 clear bits", int'(seq_bits), 0);
        check("R6 clear code", int'(char_code), 62);
        // still held: new symbols survive further ticks
        send(1'b1);
        for (int k = 0; k < HOLD + 1; k++) pulse_tick();
        check("R6 no second clear", int'(sym_count), 1);
        clr_btn = 1'b0;
        @(negedge clk);

        // R6: clear wins over a same-cycle symbol
        clr_btn = 1'b1;
        for (int k = 0; k < HOLD - 1; k++) pulse_tick();
        tick = 1'b1;
        sym_valid = 1'b1;
        sym_dash = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        sym_valid = 1'b0;
        sym_dash = 1'b0;
        check("R6 clear priority count", int'(sym_count), 0);
        check("R6 clear priority bits", int'(seq_bits), 0);
        clr_btn = 1'b0;
        @(negedge clk);

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule